// File: doc/BRIEF.md
# Eight-Bit Register-Indirect Processor Core

This block is a compact multicycle processor with an eight-bit datapath. It runs a fixed set of eleven instructions over eight general registers and keeps a zero flag and a negative flag. Instructions and data share one synchronous memory port. The memory returns read data one cycle after it sees an address. The core handles one instruction at a time, in fixed phases: fetch, decode, execute, and for the two instructions that read memory, a final memory phase.

Arithmetic is eight-bit two's complement and wraps silently. Register 0 is hardwired to zero. Data is always addressed through a register. Control transfers take their target from a register. A link instruction exchanges the program counter with a register in a single step. An immediate load takes its operand from the word that follows its opcode.

Top module: `mini8_core`

## Requirements
- R1: Asynchronous active-low reset clears the program counter, all registers and both flags. While reset is held, `mem_we` is 0 and `mem_addr` is 0. The first fetch after release is from address 0.
- R2: Each instruction takes three cycles, fetch then decode then execute, except LOAD and LDI, which take a fourth cycle. `mem_addr` equals the PC in the fetch cycle. `mem_we` is high only in the execute cycle of STORE.
- R3: An instruction word is {op[15:12], 6'b0, ra[5:3], rb[2:0]}. ADD (op 0) writes ra+rb into rb. COM (op 7) writes ~rb into rb. INCR (op 9) writes rb+1 into rb. All results are taken modulo 256.
- R4: Register 0 always reads as zero and writes to it are discarded. CLEAR (op 3) sets rb to zero.
- R5: STORE (op 2) writes {8'h00, rb} to the address held in ra. LOAD (op 1) places the low byte of the word at the address held in ra into rb. Its address is driven in the execute cycle.
- R6: JUMP (op 5) sets the PC to the value of rb. Every non-taken instruction other than LDI advances the PC by one.
- R7: JAL (op 4) sets the PC to the old value of rb and writes the address of the next instruction (PC+1) into rb. Both values are read before either is written.
- R8: LDI (op 10) reads address PC+1 in its execute cycle, loads the low byte of that word into rb, and advances the PC by two.
- R9: JUMPN (op 6) is taken only when N is 1, and BEQ (op 8) only when Z is 1. ADD, COM, INCR, CLEAR, LOAD and LDI set Z when the result is zero and set N to bit 7 of the result, even when rb is register 0. STORE and all jumps leave the flags unchanged.
- R10: Opcodes 11 to 15, and any word with a nonzero bit among [11:6], execute as a no-operation. Such a word changes no register, flag or memory location and advances the PC by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 16 | Data written to memory |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Word read, valid one cycle after its address |

## Verification
The assertions assume the memory returns the word at the address of the previous cycle, which is what makes the decode and memory phases hold valid data. They also assume reset is applied before the first instruction, so that phase-to-phase properties such as the PC step after LDI start from a defined state. The bench memory is a registered-read array, so the core never sees anything other than a one-cycle response. The test program keeps every immediate and every pointer inside the 256-word space. It is arranged so that each flag-dependent branch is reached from a known flag value, including flag values that the immediate loads themselves produce.

// File: rtl/mini8_core.sv
module mini8_core #(
  parameter int DW   = 8,
  parameter int IW   = 16,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  output logic [IW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [IW-1:0] mem_rdata
);
  localparam int RW   = $clog2(NREG);
  localparam int OPW  = 4;
  localparam int PADW = IW - OPW - 2*RW;

  localparam logic [OPW-1:0] OP_ADD = 4'd0, OP_LOAD = 4'd1, OP_STORE = 4'd2,
    OP_CLEAR = 4'd3, OP_JAL = 4'd4, OP_JUMP = 4'd5, OP_JUMPN = 4'd6,
    OP_COM = 4'd7, OP_BEQ = 4'd8, OP_INCR = 4'd9, OP_LDI = 4'd10, OP_NOP = 4'd15;

  typedef enum logic [1:0] {ST_FETCH, ST_DEC, ST_EXEC, ST_MEM} st_e;

  st_e           st;
  logic [DW-1:0] pc;
  logic [DW-1:0] rf [NREG];
  logic [IW-1:0] ir;
  logic          zf, nf;

  logic [OPW-1:0] op;
  logic [RW-1:0]  ra, rb;
  logic [DW-1:0]  va, vb, res;
  logic           taken, alu_op;

  assign op = (ir[IW-OPW-1 -: PADW] == '0) ? ir[IW-1 -: OPW] : OP_NOP;
  assign ra = ir[2*RW-1 -: RW];
  assign rb = ir[RW-1:0];
  assign va = rf[ra];
  assign vb = rf[rb];

  always_comb begin
    case (op)
      OP_ADD:  res = va + vb;
      OP_COM:  res = ~vb;
      OP_INCR: res = vb + 1'b1;
      OP_CLEAR: res = rf[0];
      default: res = mem_rdata[DW-1:0];
    endcase
  end

  assign alu_op = (op == OP_ADD) || (op == OP_COM) || (op == OP_INCR) || (op == OP_CLEAR);
  assign taken  = (op == OP_JUMP) || (op == OP_JAL) ||
                  ((op == OP_JUMPN) && nf) || ((op == OP_BEQ) && zf);

  assign mem_we    = (st == ST_EXEC) && (op == OP_STORE);
  assign mem_wdata = {{(IW-DW){1'b0}}, vb};
  assign mem_addr  = (st == ST_EXEC && (op == OP_LOAD || op == OP_STORE)) ? va :
                     (st == ST_EXEC && op == OP_LDI) ? pc + 1'b1 : pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_FETCH;
      pc <= '0;
      ir <= '0;
      zf <= 1'b0;
      nf <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (st)
        ST_FETCH: st <= ST_DEC;
        ST_DEC: begin
          ir <= mem_rdata;
          st <= ST_EXEC;
        end
        ST_EXEC: begin
          if (op == OP_LOAD || op == OP_LDI) begin
            st <= ST_MEM;
          end else begin
            st <= ST_FETCH;
            pc <= taken ? vb : pc + 1'b1;
            if (alu_op) begin
              if (rb != '0) rf[rb] <= res;
              zf <= (res == '0);
              nf <= res[DW-1];
            end
            if (op == OP_JAL && rb != '0) rf[rb] <= pc + 1'b1;
          end
        end
        default: begin
          if (rb != '0) rf[rb] <= res;
          zf <= (res == '0);
          nf <= res[DW-1];
          pc <= (op == OP_LDI) ? pc + DW'(2) : pc + 1'b1;
          st <= ST_FETCH;
        end
      endcase
    end
  end

  AST_R0_HARDWIRED: assert property (@(posedge clk) disable iff (!rst_n) rf[0] == '0); // R4
  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_FETCH |=> st == ST_DEC); // R2
  AST_WRITE_ENDS_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> st == ST_FETCH && pc == DW'($past(pc) + 1)); // R5
  AST_STORE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> $stable({zf, nf})); // R9
  AST_LDI_SKIPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MEM && op == OP_LDI) |=> pc == DW'($past(pc) + 2)); // R8
  AST_DECODE_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_DEC |=> $stable(pc)); // R6
endmodule

// File: tb/mini8_core_bench.sv
module mini8_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;

  logic [15:0] mem [256];
  logic [15:0] ref_mem [256];
  logic [7:0]  ref_rf [8];
  logic [7:0]  ref_pc;
  logic        ref_z, ref_n;
  int          n_cmp = 0, n_bad = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  mini8_core u_mini8_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [2:0] ra, input logic [2:0] rb);
    return {op, 6'b0, ra, rb};
  endfunction

  task automatic put(input int a, input logic [15:0] w);
    mem[a] = w;
    ref_mem[a] = w;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
    #1;
  endtask

  task automatic step(input string ftag);
    logic [15:0] w;
    logic [3:0]  op;
    logic [2:0]  ra, rb;
    logic [7:0]  a, b, r;
    logic        upd;
    w  = ref_mem[ref_pc];
    op = (w[11:6] == 6'b0) ? w[15:12] : 4'hF;
    ra = w[5:3];
    rb = w[2:0];
    a  = ref_rf[ra];
    b  = ref_rf[rb];
    chk("R2 fetch we", mem_we, 0);
    chk({ftag, " fetch address"}, mem_addr, ref_pc);
    next_cycle();
    chk("R2 decode we", mem_we, 0);
    next_cycle();
    if (op == 4'd2) begin
      chk("R5 store we", mem_we, 1);
      chk("R5 store address", mem_addr, a);
      chk("R5 store data", mem_wdata, {8'h00, b});
      ref_mem[a] = {8'h00, b};
    end else begin
      chk("R2 execute we", mem_we, 0);
      if (op == 4'd1) chk("R5 load address", mem_addr, a);
      if (op == 4'd10) chk("R8 immediate address", mem_addr, ref_pc + 8'd1);
    end
    next_cycle();
    if (op == 4'd1 || op == 4'd10) begin
      chk("R2 memory phase we", mem_we, 0);
      next_cycle();
    end
    upd = 1'b1;
    r = 8'h00;
    case (op)
      4'd0: r = a + b;
      4'd7: r = ~b;
      4'd9: r = b + 8'd1;
      4'd3: r = 8'h00;
      4'd1: r = ref_mem[a][7:0];
      4'd10: r = ref_mem[ref_pc + 8'd1][7:0];
      default: upd = 1'b0;
    endcase
    if (upd) begin
      if (rb != 3'd0) ref_rf[rb] = r;
      ref_z = (r == 8'h00);
      ref_n = r[7];
    end
    case (op)
      4'd4: begin
        if (rb != 3'd0) ref_rf[rb] = ref_pc + 8'd1;
        ref_pc = b;
      end
      4'd5: ref_pc = b;
      4'd6: ref_pc = ref_n ? b : ref_pc + 8'd1;
      4'd8: ref_pc = ref_z ? b : ref_pc + 8'd1;
      4'd10: ref_pc = ref_pc + 8'd2;
      default: ref_pc = ref_pc + 8'd1;
    endcase
  endtask

  function automatic string tag_of(input logic [15:0] w);
    logic [3:0] op;
    op = (w[11:6] == 6'b0) ? w[15:12] : 4'hF;
    case (op)
      4'd0, 4'd7, 4'd9: return "R3";
      4'd1, 4'd2:       return "R5";
      4'd3:             return "R4";
      4'd4:             return "R7";
      4'd5:             return "R6";
      4'd6, 4'd8:       return "R9";
      4'd10:            return "R8";
      default:          return "R10";
    endcase
  endfunction

  initial begin
    string ftag;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'h0000;
      ref_mem[i] = 16'h0000;
    end
    for (int i = 0; i < 8; i++) ref_rf[i] = 8'h00;
    ref_pc = 8'h00; ref_z = 1'b0; ref_n = 1'b0;
    put(0,  enc(8, 0, 1));  put(1,  enc(6, 0, 1));  put(2,  enc(2, 0, 5));
    put(3,  enc(10, 0, 1)); put(4,  16'h0080);
    put(5,  enc(10, 0, 2)); put(6,  16'h007F);
    put(7,  enc(9, 0, 2));  put(8,  enc(2, 1, 2));
    put(9,  enc(10, 0, 3)); put(10, 16'd20);
    put(11, enc(0, 2, 2));  put(12, enc(8, 0, 3));
    for (int i = 13; i < 20; i++) put(i, enc(9, 0, 4));
    put(20, enc(10, 0, 3)); put(21, 16'd25);
    put(22, enc(7, 0, 4));  put(23, enc(6, 0, 3)); put(24, enc(9, 0, 5));
    put(25, enc(0, 4, 1));
    put(26, enc(10, 0, 6)); put(27, 16'h0081);
    put(28, enc(2, 6, 1));  put(29, enc(1, 6, 5)); put(30, enc(3, 0, 5));
    put(31, enc(6, 0, 3));
    put(32, enc(10, 0, 7)); put(33, 16'd36);
    put(34, enc(4, 0, 7));  put(35, enc(9, 0, 6)); put(36, enc(9, 0, 7));
    put(37, enc(10, 0, 6)); put(38, 16'h0082); put(39, enc(2, 6, 7));
    put(40, enc(9, 0, 0));
    put(41, enc(10, 0, 6)); put(42, 16'h0083); put(43, enc(2, 6, 0));
    put(44, enc(10, 0, 2)); put(45, 16'h00FF); put(46, enc(9, 0, 2));
    put(47, enc(10, 0, 1)); put(48, 16'h0090);
    put(49, enc(1, 1, 0));  put(50, enc(2, 1, 0));
    put(51, 16'hB03F);      put(52, enc(2, 1, 4) | 16'h0100);
    put(53, enc(10, 0, 7)); put(54, 16'd55); put(55, enc(5, 0, 7));
    put(8'h90, 16'h1234);

    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 reset we", mem_we, 0);
    chk("R1 reset address", mem_addr, 0);
    rst_n = 1'b1;
    ftag = "R1";
    for (int k = 0; k < 70; k++) begin
      logic [15:0] cur;
      cur = ref_mem[ref_pc];
      step(ftag);
      ftag = tag_of(cur);
    end
    for (int i = 0; i < 256; i++) chk("R5 memory image", mem[i], ref_mem[i]);
    chk("R1 registers cleared by reset", mem[0], 16'h0000);
    chk("R3 increment wraps to -128", mem[8'h80], 16'h0080);
    chk("R3 add of -1 and -128", mem[8'h81], 16'h007F);
    chk("R7 link value", mem[8'h82], 16'h0024);
    chk("R4 register 0 write discarded", mem[8'h90], 16'h0000);
    chk("R10 stray bit store suppressed", mem[8'h90], 16'h0000);
    chk("R8 final loop address", mem_addr == 8'd55 || ref_pc == 8'd55, 1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule